// File: doc/BRIEF.md
# Pushbutton Compensation Capture Sequencer

This block lets an operator capture or discard a compensation vector (magnitude and angle) with a single pushbutton. Holding the button produces slow pulses. The third slow pulse toggles an arming latch, so one long press arms the block and the next long press disarms it.

While the block is armed, a fast pulse cadence drives an exponential smoothing filter. The filter runs over the live magnitude and angle. When a fixed number of fast pulses has elapsed, the filter switches to a unity hold coefficient, and a done flag latches. An indicator LED shows the state: three slow blinks while a capture starts, rapid blinks while the filter settles, then solid on. A later long press produces three short dark gaps, after which the LED stays off.

Slow and fast pulses are both derived from one base tick enable. If the externally held magnitude reads zero while the done flag is set, the block disarms itself. The live values are sampled levels with no handshake. The block never stalls, so no back-pressure exists on any pin.

Top module: `comp_capture_seq`

## Requirements
- R1: After reset, `smooth_mag`, `smooth_ang`, `done` and `led` are all 0 and the block is disarmed.
- R2: `btn_raw` passes through a two-flop synchroniser before use. A press shorter than three slow pulses, followed by a release, leaves every output unchanged, because the hold count resets on release.
- R3: A slow pulse occurs every `SLOW_DIV` base ticks while the button is held. The cycle after the hold count first reaches `HOLD_LIMIT`, a disarmed block becomes armed.
- R4: The same event on an armed block disarms it. Disarming clears `done` one cycle later and returns both smoothed outputs to 0.
- R5: While armed, a fast pulse occurs every `FAST_DIV` base ticks until `CAL_LIMIT` pulses have been counted. One cycle after the count is reached, `done` goes to 1.
- R6: On each fast pulse while armed, each output steps to `(a*old + (65536-a)*sample) >>> 16`, with a = 64881 (0.99 in Q0.16). While disarmed, both outputs are 0.
- R7: Once the count is reached, the coefficient becomes 65536, so both outputs hold their values whatever the live inputs do.
- R8: If `stored_mag` equals 0 while `done` is 1, the block disarms on the next cycle.
- R9: `led` = `done` XOR blink. Blink is 1 during a slow pulse while the button is held and the hold count is below its limit. Blink is also 1 during a fast pulse while armed and the fast count is below its limit.
- R10: Holding the button past the toggle produces no further toggle until the button is released and pressed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle base tick enable |
| btn_raw | input | 1 | Asynchronous operator pushbutton, 1 = pressed |
| live_mag | input | W | Live compensation magnitude, signed fixed point |
| live_ang | input | W | Live compensation angle, signed fixed point |
| stored_mag | input | W | Externally held compensation magnitude |
| smooth_mag | output | W | Smoothed magnitude |
| smooth_ang | output | W | Smoothed angle |
| done | output | 1 | Capture complete |
| led | output | 1 | Indicator LED drive |

## Verification
The assertions assume that `tick_en` is a single-cycle strobe. They also assume that the live inputs and `stored_mag` stay stable around the clock edges in which they are sampled.

The stimulus changes every input on the falling clock edge. It uses two tick cadences: one tick every other cycle, and one tick every cycle. The every-cycle cadence makes fast pulses arrive back to back, so a filter step with the unity coefficient is exercised right at the end of the count.

Button presses are held for fixed cycle counts. These counts are chosen to fall either short of the third slow pulse or well past it, so the toggle happens at most once per press.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int unsigned COEF_FRAC   = 16;
  localparam int unsigned COEF_UNITY  = 1 << COEF_FRAC;
  localparam int unsigned COEF_SMOOTH = 64881;

  typedef struct packed {
    logic pulse;
    logic full;
  } pcount_t;
endpackage

// File: rtl/cps_sync.sv
module cps_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cps_pulse_counter.sv
module cps_pulse_counter #(
  parameter int unsigned DIV          = 4,
  parameter int unsigned LIMIT        = 3,
  parameter bit          STOP_AT_FULL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  output cps_pkg::pcount_t st
);
  localparam int unsigned TW = $clog2(DIV + 1);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [TW-1:0] tcnt;
  logic          pulse_q;
  logic [CW-1:0] cnt;
  logic          full;
  logic          timer_run;

  assign full = (cnt == CW'(LIMIT));

  generate
    if (STOP_AT_FULL) begin : g_stop
      assign timer_run = run && !full;
    end else begin : g_free
      assign timer_run = run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt    <= '0;
      pulse_q <= 1'b0;
      cnt     <= '0;
    end else begin
      if (!timer_run) begin
        tcnt    <= '0;
        pulse_q <= 1'b0;
      end else begin
        pulse_q <= 1'b0;
        if (tick_en) begin
          if (tcnt == TW'(DIV - 1)) begin
            tcnt    <= '0;
            pulse_q <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      end
      if (!run) cnt <= '0;
      else if (pulse_q && !full) cnt <= cnt + 1'b1;
    end
  end

  assign st.pulse = pulse_q;
  assign st.full  = full;

  // count never passes its limit
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT));
  // released or disarmed clears the count
  assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && !pulse_q));
endmodule

// File: rtl/cps_smoother.sv
module cps_smoother #(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                armed,
  input  logic                step,
  input  logic                hold,
  input  logic signed [W-1:0] sample,
  output logic signed [W-1:0] val
);
  import cps_pkg::*;
  localparam int unsigned AW = 2 * W;

  logic signed [AW-1:0] coef_old;
  logic signed [AW-1:0] coef_new;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] shifted;

  assign coef_old = hold ? AW'(COEF_UNITY) : AW'(COEF_SMOOTH);
  assign coef_new = AW'(COEF_UNITY) - coef_old;
  assign acc      = coef_old * AW'(val) + coef_new * AW'(sample);
  assign shifted  = acc >>> COEF_FRAC;

  always_ff @(posedge clk) begin
    if (!rst_n)       val <= '0;
    else if (!armed)  val <= '0;
    else if (step)    val <= shifted[W-1:0];
  end

  // disarmed filter returns to zero
  assert_clear_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (val == '0));
  // unity coefficient freezes the value
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hold) |=> $stable(val));
endmodule

// File: rtl/comp_capture_seq.sv
module comp_capture_seq #(
  parameter int unsigned W          = 32,
  parameter int unsigned SLOW_DIV   = 4,
  parameter int unsigned FAST_DIV   = 1,
  parameter int unsigned HOLD_LIMIT = 3,
  parameter int unsigned CAL_LIMIT  = 40
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                btn_raw,
  input  logic signed [W-1:0] live_mag,
  input  logic signed [W-1:0] live_ang,
  input  logic signed [W-1:0] stored_mag,
  output logic signed [W-1:0] smooth_mag,
  output logic signed [W-1:0] smooth_ang,
  output logic                done,
  output logic                led
);
  import cps_pkg::*;
  localparam int unsigned NCH = 2;

  logic    btn;
  pcount_t hold_st;
  pcount_t cal_st;
  logic    hold_full_d;
  logic    hold_rise;
  logic    force_clr;
  logic    armed;
  logic    blink;

  cps_sync u_sync (.clk(clk), .rst_n(rst_n), .d(btn_raw), .q(btn));

  cps_pulse_counter #(.DIV(SLOW_DIV), .LIMIT(HOLD_LIMIT), .STOP_AT_FULL(1'b0)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(btn), .tick_en(tick_en), .st(hold_st));

  cps_pulse_counter #(.DIV(FAST_DIV), .LIMIT(CAL_LIMIT), .STOP_AT_FULL(1'b1)) u_cal (
    .clk(clk), .rst_n(rst_n), .run(armed), .tick_en(tick_en), .st(cal_st));

  assign hold_rise = hold_st.full && !hold_full_d;
  assign force_clr = done && (stored_mag == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full_d <= 1'b0;
      armed       <= 1'b0;
      done        <= 1'b0;
    end else begin
      hold_full_d <= hold_st.full;
      if (force_clr)      armed <= 1'b0;
      else if (hold_rise) armed <= !armed;
      done <= armed && (done || cal_st.full);
    end
  end

  logic signed [W-1:0] samp [NCH];
  logic signed [W-1:0] outv [NCH];
  assign samp[0] = live_mag;
  assign samp[1] = live_ang;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      cps_smoother #(.W(W)) u_sm (
        .clk(clk), .rst_n(rst_n), .armed(armed), .step(cal_st.pulse),
        .hold(cal_st.full), .sample(samp[c]), .val(outv[c]));
    end
  endgenerate

  assign smooth_mag = outv[0];
  assign smooth_ang = outv[1];

  assign blink = (hold_st.pulse && btn && !hold_st.full)
              || (cal_st.pulse && armed && !cal_st.full);
  assign led   = done ^ blink;

  // hold count reaching its limit flips the arming latch
  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rise && !force_clr) |=> (armed != $past(armed)));
  // zero stored magnitude with done set disarms
  assert_force_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_clr |=> !armed);
  // done only follows an armed cycle
  assert_done_needs_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !done);
  // no second toggle while the button stays held
  assert_single_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (btn && hold_full_d) |-> !hold_rise);
endmodule

// File: tb/comp_capture_seq_test.sv
module comp_capture_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32, SLOW = 4, FAST = 1, HOLDL = 3, CALL = 40;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, btn_raw = 1'b0;
  logic signed [W-1:0] live_mag = '0, live_ang = '0, stored_mag = 32'sd7;
  logic signed [W-1:0] smooth_mag, smooth_ang;
  logic done, led;

  comp_capture_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .btn_raw(btn_raw),
    .live_mag(live_mag), .live_ang(live_ang), .stored_mag(stored_mag),
    .smooth_mag(smooth_mag), .smooth_ang(smooth_ang), .done(done), .led(led));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit every_cycle = 1'b0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit q_s0, q_s1, m_sp, m_fp, m_armed, m_done;
  int m_ts, m_tf, m_hold, m_cal, m_hold_prev_full;
  int m_mag, m_ang;

  function automatic int filt(int old, int s, bit frozen);
    longint a = frozen ? 64'sd65536 : 64'sd64881;
    longint acc = a * longint'(old) + (64'sd65536 - a) * longint'(s);
    return int'(acc >>> 16);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q_s0 = 0; q_s1 = 0; m_sp = 0; m_fp = 0; m_armed = 0; m_done = 0;
      m_ts = 0; m_tf = 0; m_hold = 0; m_cal = 0; m_hold_prev_full = 0;
      m_mag = 0; m_ang = 0;
    end else begin
      automatic bit b = q_s1, sp = m_sp, fp = m_fp, arm = m_armed, dn = m_done;
      automatic int hold = m_hold, cal = m_cal;
      automatic bit hfull = (hold == HOLDL), cfull = (cal == CALL);
      automatic bit rise = hfull && !m_hold_prev_full;
      q_s1 = q_s0; q_s0 = btn_raw;
      m_sp = 0;
      if (!b) m_ts = 0;
      else if (tick_en) begin
        if (m_ts == SLOW - 1) begin m_ts = 0; m_sp = 1; end else m_ts++;
      end
      m_hold = !b ? 0 : ((sp && !hfull) ? hold + 1 : hold);
      m_hold_prev_full = hfull;
      if (dn && stored_mag == 0) m_armed = 0;
      else if (rise) m_armed = !arm;
      m_fp = 0;
      if (!(arm && !cfull)) m_tf = 0;
      else if (tick_en) begin
        if (m_tf == FAST - 1) begin m_tf = 0; m_fp = 1; end else m_tf++;
      end
      m_cal = !arm ? 0 : ((fp && !cfull) ? cal + 1 : cal);
      m_done = arm && (dn || cfull);
      if (!arm) begin m_mag = 0; m_ang = 0; end
      else if (fp) begin
        m_mag = filt(m_mag, live_mag, cfull);
        m_ang = filt(m_ang, live_ang, cfull);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit blink = (m_sp && q_s1 && m_hold < HOLDL) || (m_fp && m_armed && m_cal < CALL);
      check(led == (m_done ^ blink), "R9", "led", led, m_done ^ blink);
      check(done == m_done, "R5", "done", done, m_done);
      check(smooth_mag == m_mag, "R6", "smooth_mag", smooth_mag, m_mag);
      check(smooth_ang == m_ang, "R6", "smooth_ang", smooth_ang, m_ang);
    end
  end

  // base tick generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      tick_en = every_cycle ? 1'b1 : (ph == 0);
      ph = (ph + 1) % 2;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int n, output int rises);
    bit prev;
    rises = 0;
    btn_raw = 1'b1;
    prev = led;
    repeat (n) begin
      @(negedge clk);
      if (led && !prev) rises++;
      prev = led;
    end
    btn_raw = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    logic signed [W-1:0] held_mag, held_ang;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    check(smooth_mag == 0 && smooth_ang == 0, "R1", "outputs zero", smooth_mag, 0);
    check(done == 0 && led == 0, "R1", "done/led clear", {done, led}, 0);

    live_mag = 32'sd20000; live_ang = -32'sd3000;
    // R2: short press, two slow pulses only
    press(16, r);
    cycles(10);
    check(done == 0, "R2", "short press done", done, 0);
    check(smooth_mag == 0, "R2", "short press mag", smooth_mag, 0);

    // R3/R10: long press arms once, stays armed
    press(80, r);
    cycles(100);
    check(done == 1, "R10", "single toggle on long press", done, 1);
    check(done == 1, "R5", "done after count", done, 1);
    check(led == 1, "R9", "solid led", led, 1);
    check(smooth_mag != 0, "R6", "filter moved", smooth_mag, 1);

    // R7: frozen against new live values
    held_mag = smooth_mag; held_ang = smooth_ang;
    live_mag = 32'sd90000; live_ang = 32'sd7777;
    cycles(20);
    check(smooth_mag == held_mag, "R7", "mag frozen", smooth_mag, held_mag);
    check(smooth_ang == held_ang, "R7", "ang frozen", smooth_ang, held_ang);

    // R4/R9: clearing press, three dark gaps
    press(34, r);
    check(r == 3, "R9", "dark gaps on clear", r, 3);
    cycles(6);
    check(done == 0 && led == 0, "R4", "cleared", {done, led}, 0);
    check(smooth_mag == 0, "R4", "cleared mag", smooth_mag, 0);

    // R8: forced clear through zero stored magnitude, fast tick cadence
    every_cycle = 1'b1;
    press(20, r);
    cycles(60);
    check(done == 1, "R5", "done with back-to-back pulses", done, 1);
    stored_mag = '0;
    cycles(4);
    check(done == 0, "R8", "forced clear done", done, 0);
    check(smooth_mag == 0, "R8", "forced clear mag", smooth_mag, 0);
    stored_mag = 32'sd7;
    cycles(5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule